// File: doc/BRIEF.md
# Latched Interrupt Event Register Set

This block gathers three internal interrupt requests and turns them into a single active-low device interrupt pin. Software sees the requests through four 32-bit registers, each using one field at bit 15. A latched event register catches any request and keeps it. A mask register gates the pin. A present-state register shows the live requests. A force register lets software raise an event for debug.

The requests arrive already enabled by local source controls that sit outside this block. The block only adds gating on top of those controls. An enable input switches the status registers into the pin path. While the enable is low, the pin follows the live requests directly. While it is high, the pin asserts only when a latched event meets a set mask. Once asserted, it stays asserted until software either clears the mask or writes a 1 to the event bit.

Top module: `evt_irq_regs`

## Requirements
- R1: After reset the event bit and the mask bit are 0 and `irq_no` is high (deasserted).
- R2: A read at offset 0x8 returns the live OR of the three requests at bit 15, with no clock delay.
- R3: The event bit (offset 0x0, bit 15) sets one clock after any request is high and holds after the request falls. This happens whatever the enable input is.
- R4: Writing 1 to bit 15 at offset 0x0 clears the event bit. Writing 0 there leaves it unchanged.
- R5: If a request or a force write is active in the same cycle as a clear, the event bit stays set.
- R6: Writing 1 to bit 15 at offset 0xC sets the event bit. Writing 0 there has no effect. Offset 0xC always reads as zero.
- R7: The mask bit (offset 0x4, bit 15) is written and read back at that position, and it changes only on a write to 0x4.
- R8: With the enable high, `irq_no` goes low one clock after the event bit and the mask bit are both 1.
- R9: With the enable high, `irq_no` returns high one clock after the event bit or the mask bit is 0.
- R10: With the enable low, `irq_no` equals the inverted live OR of the requests, one clock later. Event and mask then play no part.
- R11: Every bit other than bit 15 reads as zero. Offsets other than 0x0, 0x4, 0x8 and 0xC read as zero, and writes to them or to 0x8 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Register byte offset |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| req_i | input | 3 | Internal interrupt requests, already source-enabled |
| stat_en_i | input | 1 | Switches the event/mask path into the pin |
| irq_no | output | 1 | Device interrupt pin, active low, registered |

## Verification
If the event bit is wrongly held, the fault shows in the read at 0x0 on the very next cycle. It also shows on `irq_no` one cycle after that, once the mask is set. So a lost set, a missed clear or a clear that wins against a live request each appears within two clocks. If the mask has the wrong value, or if the enable selects the wrong path, the pin is wrong exactly one clock after the condition arises. The bench holds each stimulus for two clocks and then samples both the reads and the pin, so every such fault lands on a check.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_EVT   = 4'h0,
    REG_MASK  = 4'h4,
    REG_LIVE  = 4'h8,
    REG_FORCE = 4'hC
  } reg_ofs_e;
endpackage

// File: rtl/evt_irq_decode.sv
`timescale 1ns/1ps
module evt_irq_decode
  import evt_irq_pkg::*;
(
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bit_i,
  output logic              clr_o,
  output logic              set_o,
  output logic              mask_wr_o
);
  always_comb begin
    clr_o     = 1'b0;
    set_o     = 1'b0;
    mask_wr_o = 1'b0;
    if (we_i) begin
      case (addr_i)
        REG_EVT:   clr_o     = bit_i;
        REG_FORCE: set_o     = bit_i;
        REG_MASK:  mask_wr_o = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/evt_irq_state.sv
`timescale 1ns/1ps
module evt_irq_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic live_i,
  input  logic clr_i,
  input  logic set_i,
  input  logic mask_wr_i,
  input  logic mask_val_i,
  output logic ev_q,
  output logic mask_q
);
  // set sources dominate a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ev_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      ev_q <= (ev_q & ~clr_i) | live_i | set_i;
      if (mask_wr_i) mask_q <= mask_val_i;
    end
  end

  // R3
  ev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(ev_q) && !$past(clr_i) |-> ev_q);
  // R5
  ev_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(live_i || set_i) |-> ev_q);
  // R4
  ev_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(clr_i && !live_i && !set_i) |-> !ev_q);
  // R7
  mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(mask_wr_i) |-> mask_q == $past(mask_q));
endmodule

// File: rtl/evt_irq_pin.sv
`timescale 1ns/1ps
module evt_irq_pin (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ev_i,
  input  logic mask_i,
  input  logic live_i,
  output logic irq_no
);
  logic assert_d;
  assign assert_d = en_i ? (ev_i & mask_i) : live_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~assert_d;
  end

  // R8
  pin_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(en_i && ev_i && mask_i) |-> !irq_no);
  // R9
  pin_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(en_i && !(ev_i && mask_i)) |-> irq_no);
  // R10
  pin_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(!en_i) |-> irq_no == !$past(live_i));
endmodule

// File: rtl/evt_irq_regs.sv
`timescale 1ns/1ps
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int N_REQ    = 3,
  parameter int INTR_BIT = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_REQ-1:0]  req_i,
  input  logic              stat_en_i,
  output logic              irq_no
);
  localparam logic [DATA_W-1:0] FIELD = DATA_W'(1) << INTR_BIT;

  logic live, clr, set, mask_wr, ev_q, mask_q;
  logic unused_wdata;

  assign live         = |req_i;
  assign unused_wdata = ^(wdata_i & ~FIELD);

  evt_irq_decode u_dec (
    .we_i      (we_i),
    .addr_i    (addr_i),
    .bit_i     (wdata_i[INTR_BIT]),
    .clr_o     (clr),
    .set_o     (set),
    .mask_wr_o (mask_wr)
  );

  evt_irq_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .live_i     (live),
    .clr_i      (clr),
    .set_i      (set),
    .mask_wr_i  (mask_wr),
    .mask_val_i (wdata_i[INTR_BIT]),
    .ev_q       (ev_q),
    .mask_q     (mask_q)
  );

  evt_irq_pin u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (stat_en_i),
    .ev_i   (ev_q),
    .mask_i (mask_q),
    .live_i (live),
    .irq_no (irq_no)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_EVT:  rdata_o[INTR_BIT] = ev_q;
      REG_MASK: rdata_o[INTR_BIT] = mask_q;
      REG_LIVE: rdata_o[INTR_BIT] = live;
      default:  ;
    endcase
  end

  // R11
  rdata_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~FIELD) == '0);
endmodule

// File: tb/evt_irq_regs_tb.sv
`timescale 1ns/1ps
module evt_irq_regs_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] rdata_o;
  logic [2:0]  req_i = '0;
  logic        stat_en_i = 1'b1;
  logic        irq_no;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  evt_irq_regs dut_i (.*);

  typedef struct packed {
    logic [2:0] req;
    logic       en;
    logic       we;
    logic [3:0] addr;
    logic       wb;
    logic       ev;
    logic       m;
    logic       pin;
    logic       live;
  } vec_t;

  // req en we addr wb | ev m pin live
  localparam vec_t VECS [18] = '{
    '{3'b000,1'b1,1'b0,4'h0,1'b0, 1'b0,1'b0,1'b1,1'b0}, // R1 idle
    '{3'b001,1'b1,1'b0,4'h0,1'b0, 1'b1,1'b0,1'b1,1'b1}, // R3 latch, masked off
    '{3'b000,1'b1,1'b0,4'h0,1'b0, 1'b1,1'b0,1'b1,1'b0}, // R3 hold
    '{3'b000,1'b1,1'b1,4'h4,1'b1, 1'b1,1'b1,1'b0,1'b0}, // R7 R8 mask on
    '{3'b000,1'b1,1'b1,4'h0,1'b0, 1'b1,1'b1,1'b0,1'b0}, // R4 write 0 ignored
    '{3'b000,1'b1,1'b1,4'h0,1'b1, 1'b0,1'b1,1'b1,1'b0}, // R4 R9 clear
    '{3'b100,1'b1,1'b1,4'h0,1'b1, 1'b1,1'b1,1'b0,1'b1}, // R5 set wins
    '{3'b000,1'b1,1'b1,4'h4,1'b0, 1'b1,1'b0,1'b1,1'b0}, // R9 mask off
    '{3'b000,1'b1,1'b1,4'h0,1'b1, 1'b0,1'b0,1'b1,1'b0}, // R4 clear
    '{3'b000,1'b1,1'b1,4'hC,1'b1, 1'b1,1'b0,1'b1,1'b0}, // R6 force
    '{3'b000,1'b1,1'b1,4'h4,1'b1, 1'b1,1'b1,1'b0,1'b0}, // R8
    '{3'b000,1'b0,1'b0,4'h0,1'b0, 1'b1,1'b1,1'b1,1'b0}, // R10 bypass idle
    '{3'b010,1'b0,1'b0,4'h0,1'b0, 1'b1,1'b1,1'b0,1'b1}, // R10 bypass live
    '{3'b000,1'b0,1'b1,4'h0,1'b1, 1'b0,1'b1,1'b1,1'b0}, // R4 R10
    '{3'b000,1'b1,1'b1,4'hC,1'b0, 1'b0,1'b1,1'b1,1'b0}, // R6 force 0 ignored
    '{3'b000,1'b1,1'b1,4'h8,1'b1, 1'b0,1'b1,1'b1,1'b0}, // R11 read-only
    '{3'b000,1'b1,1'b1,4'h2,1'b1, 1'b0,1'b1,1'b1,1'b0}, // R11 unmapped
    '{3'b111,1'b1,1'b0,4'h0,1'b0, 1'b1,1'b1,1'b0,1'b1}  // R3 R8 all requests
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #0.3;
    d = rdata_o;
  endtask

  initial begin
    logic [31:0] d;
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    rd(4'h0, d); check("R1 event", d, 32'h0);
    rd(4'h4, d); check("R1 mask", d, 32'h0);
    check("R1 pin", {31'b0, irq_no}, 32'h1);

    foreach (VECS[i]) begin
      req_i = VECS[i].req; stat_en_i = VECS[i].en; we_i = VECS[i].we;
      addr_i = VECS[i].addr; wdata_i = {16'h0, VECS[i].wb, 15'h0};
      @(posedge clk_i); @(negedge clk_i);
      we_i = 1'b0;
      @(posedge clk_i); @(negedge clk_i);
      rd(4'h0, d); check($sformatf("R3/R4/R5/R6 vec%0d event", i), d, {16'h0, VECS[i].ev, 15'h0});
      rd(4'h4, d); check($sformatf("R7 vec%0d mask", i), d, {16'h0, VECS[i].m, 15'h0});
      rd(4'h8, d); check($sformatf("R2 vec%0d live", i), d, {16'h0, VECS[i].live, 15'h0});
      check($sformatf("R8/R9/R10 vec%0d pin", i), {31'b0, irq_no}, {31'b0, VECS[i].pin});
    end

    // state now: ev=1 mask=1 req=7 en=1; clear and drop requests
    req_i = 3'b000; addr_i = 4'h0; wdata_i = 32'h8000; we_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); we_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    check("R9 pin after clear", {31'b0, irq_no}, 32'h1);

    // R8 latency: request -> event next edge -> pin the edge after
    req_i = 3'b001;
    @(posedge clk_i); @(negedge clk_i);
    req_i = 3'b000;
    rd(4'h0, d); check("R3 event after one edge", d, 32'h8000);
    check("R8 pin not yet low", {31'b0, irq_no}, 32'h1);
    @(posedge clk_i); @(negedge clk_i);
    check("R8 pin low second edge", {31'b0, irq_no}, 32'h0);

    // R2 live read is combinational
    req_i = 3'b100; rd(4'h8, d); check("R2 live no clock", d, 32'h8000);
    req_i = 3'b000; rd(4'h8, d); check("R2 live drop", d, 32'h0);

    // R11 full-word mask write, force reads zero, unmapped reads zero
    addr_i = 4'h4; wdata_i = 32'hFFFF_FFFF; we_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); we_i = 1'b0;
    rd(4'h4, d); check("R11 mask only bit15", d, 32'h8000);
    rd(4'hC, d); check("R6 force reads zero", d, 32'h0);
    rd(4'h3, d); check("R11 unmapped read", d, 32'h0);

    // R10 bypass latency with event cleared and mask set
    addr_i = 4'h0; wdata_i = 32'h8000; we_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); we_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    stat_en_i = 1'b0; req_i = 3'b010;
    @(posedge clk_i); @(negedge clk_i);
    check("R10 bypass one edge", {31'b0, irq_no}, 32'h0);
    req_i = 3'b000;
    @(posedge clk_i); @(negedge clk_i);
    check("R10 bypass release", {31'b0, irq_no}, 32'h1);
    rd(4'h0, d); check("R3 latched while bypassed", d, 32'h8000);

    // R1 asynchronous reset mid-run
    rst_ni = 1'b0; #0.5;
    check("R1 pin on reset", {31'b0, irq_no}, 32'h1);
    rd(4'h4, d); check("R1 mask on reset", d, 32'h0);
    rst_ni = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule